// File: doc/BRIEF.md
# Parallel Printer Port Register Block

This block sits between a simple byte-wide CPU bus and the pins of a legacy printer-style parallel port. Software sees three byte registers at consecutive offsets. They hold a data latch, a read-only view of five status inputs, and a control register. The control register drives four open-collector handshake lines, selects the direction of the data bus and gates an interrupt.

Every pin input passes through a two-flop synchronizer before it is read or edge-detected. The data pins can be released to high impedance, so that an external device can drive a byte into the host. The control lines are always read back from their pins, not from the register, so a device that pulls a released line low is seen by software. A falling edge on the acknowledge input raises a one-cycle interrupt pulse when interrupts are enabled.

Top module: `pport_regs`

## Requirements
- R1: After reset the data latch is 0x00 and the data pins are driven. Reading the control register with no external pulls returns 0x04. No control line is pulled low. The interrupt enable output is 0.
- R2: A write to offset 0 places the byte on `data_pin_out`. The byte stays there until the next write to offset 0.
- R3: A read of offset 0 returns the synchronized level of `data_pin_in`, not the latch contents.
- R4: While control bit 5 is 1, `data_pin_oe` is 0. Writes to offset 0 are still stored, and the stored byte is driven again once bit 5 returns to 0.
- R5: A read of offset 1 returns `{~busy, ack, paper_out, selected, error, 3'b111}`. Here `stat_pin_in` is ordered [4]=busy, [3]=ack, [2]=paper_out, [1]=selected, [0]=error.
- R6: A write to offset 1 changes no output and no readable register.
- R7: Each control line `g` is pulled low (`ctl_pin_drive_low[g]`=1) when register bit `g` is 1 for lines 0, 1 and 3. For line 2 it is pulled low when register bit 2 is 0. This gives inversion mask 4'b1011.
- R8: Control read bits 3:0 are the synchronized `ctl_pin_in` levels with the same mask applied. A line held low by an external device is visible even when the register releases it.
- R9: Writing 0100 binary to control bits 3:0 releases all four lines.
- R10: Control read bits 5:4 return the stored bidirectional and interrupt-enable bits. Bits 7:6 read 0.
- R11: With control bit 4 set, each falling edge of the ack pin yields exactly one `irq_pulse` lasting one cycle. A rising edge yields none.
- R12: With control bit 4 clear, `irq_oe` is 0 and ack edges produce no pulse. With bit 4 set, `irq_oe` is 1.
- R13: Offset 3 reads 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_sel | input | 1 | Bus access strobe |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 2 | Register offset |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the offset on `cpu_addr` |
| data_pin_out | output | 8 | Data latch toward the pins |
| data_pin_oe | output | 1 | Data pin driver enable |
| data_pin_in | input | 8 | Data pin levels |
| ctl_pin_drive_low | output | 4 | Open-collector pull-down per control line |
| ctl_pin_in | input | 4 | Control pin levels |
| stat_pin_in | input | 5 | Status pins: busy, ack, paper out, selected, error |
| irq_pulse | output | 1 | One-cycle interrupt per ack falling edge |
| irq_oe | output | 1 | Interrupt line buffer enable |

## Verification
The bench targets three corner cases.

- **Open-collector readback.** External pulls are made on lines the register releases. A design that read back the register instead of the pins would miss the pull, and a wrong inversion mask would flip individual bits.
- **Input mode.** The bench checks that data reads follow the external byte rather than the latch, and that a byte written in input mode appears on the pins only after the mode is left. A design that dropped such writes would drive a stale value.
- **Acknowledge interrupt.** The bench counts pulses on falling and rising edges, both enabled and disabled. A level-triggered or ungated design would give a wrong count.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int CTL_W  = 4;
  localparam int STAT_W = 5;
  localparam int SYNC_STAGES = 2;

  localparam logic [ADDR_W-1:0] OFS_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 2'd2;

  // 1 = line active low (register 1 pulls pin low)
  localparam logic [CTL_W-1:0] CTL_INV_MASK = 4'b1011;
  localparam logic [CTL_W-1:0] CTL_LINES_RST = 4'b0100;
  localparam logic [DATA_W-1:0] DATA_RST = '0;

  typedef struct packed {
    logic             bidir;
    logic             ien;
    logic [CTL_W-1:0] lines;
  } ctrl_t;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stage_q;
  logic [STAGES-1:0][W-1:0] stage_nx;

  always_comb begin
    stage_nx[0] = d;
    for (int i = 1; i < STAGES; i++) stage_nx[i] = stage_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_nx;
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pport_host_regs.sv
module pport_host_regs
  import pport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] data_q,
  output ctrl_t             ctrl_q
);
  logic              data_we;
  logic              ctrl_we;
  logic [DATA_W-1:0] data_nx;
  ctrl_t             ctrl_nx;

  always_comb begin
    data_we = wr_en && (addr == OFS_DATA);
    ctrl_we = wr_en && (addr == OFS_CTRL);
    data_nx = data_q;
    ctrl_nx = ctrl_q;
    if (data_we) data_nx = wdata;
    if (ctrl_we) ctrl_nx = ctrl_t'(wdata[CTL_W+1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= DATA_RST;
      ctrl_q <= '{bidir: 1'b0, ien: 1'b0, lines: CTL_LINES_RST};
    end else begin
      if (data_we) data_q <= data_nx;
      if (ctrl_we) ctrl_q <= ctrl_nx;
    end
  end
endmodule

// File: rtl/pport_ack_irq.sv
module pport_ack_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_s,
  input  logic ien,
  output logic irq_pulse
);
  logic ack_d;
  logic pulse_q;
  logic pulse_nx;

  always_comb pulse_nx = ien && ack_d && !ack_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_d   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      ack_d   <= ack_s;
      pulse_q <= pulse_nx;
    end
  end

  assign irq_pulse = pulse_q;

  // R11: a pulse never spans two cycles
  p_irq_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);
  // R12: a pulse only follows a cycle with interrupts enabled
  p_irq_enabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(ien));
endmodule

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_sel,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [DATA_W-1:0] data_pin_out,
  output logic              data_pin_oe,
  input  logic [DATA_W-1:0] data_pin_in,
  output logic [CTL_W-1:0]  ctl_pin_drive_low,
  input  logic [CTL_W-1:0]  ctl_pin_in,
  input  logic [STAT_W-1:0] stat_pin_in,
  output logic              irq_pulse,
  output logic              irq_oe
);
  localparam int STAT_UNDEF_W = DATA_W - STAT_W;
  localparam int CTRL_PAD_W   = DATA_W - CTL_W - 2;

  logic [DATA_W-1:0] data_q;
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] data_s;
  logic [CTL_W-1:0]  ctl_s;
  logic [STAT_W-1:0] stat_s;
  logic [CTL_W-1:0]  ctl_rd;
  logic              wr_en;

  assign wr_en = cpu_sel && cpu_wr;

  pport_host_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(cpu_addr),
    .wdata(cpu_wdata), .data_q(data_q), .ctrl_q(ctrl_q)
  );

  pport_sync #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_sync_data (
    .clk(clk), .rst_n(rst_n), .d(data_pin_in), .q(data_s)
  );
  pport_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .d(ctl_pin_in), .q(ctl_s)
  );
  pport_sync #(.W(STAT_W), .STAGES(SYNC_STAGES)) u_sync_stat (
    .clk(clk), .rst_n(rst_n), .d(stat_pin_in), .q(stat_s)
  );

  pport_ack_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ack_s(stat_s[STAT_W-2]),
    .ien(ctrl_q.ien), .irq_pulse(irq_pulse)
  );

  // per-line polarity between register bit and open-collector pin
  for (genvar g = 0; g < CTL_W; g++) begin : g_ctl_line
    if (CTL_INV_MASK[g]) begin : g_inv
      assign ctl_pin_drive_low[g] = ctrl_q.lines[g];
      assign ctl_rd[g]            = ~ctl_s[g];
    end else begin : g_true
      assign ctl_pin_drive_low[g] = ~ctrl_q.lines[g];
      assign ctl_rd[g]            = ctl_s[g];
    end
  end

  assign data_pin_out = data_q;
  assign data_pin_oe  = ~ctrl_q.bidir;
  assign irq_oe       = ctrl_q.ien;

  always_comb begin
    case (cpu_addr)
      OFS_DATA: cpu_rdata = data_s;
      OFS_STAT: cpu_rdata = {~stat_s[STAT_W-1], stat_s[STAT_W-2:0],
                             {STAT_UNDEF_W{1'b1}}};
      OFS_CTRL: cpu_rdata = {{CTRL_PAD_W{1'b0}}, ctrl_q.bidir, ctrl_q.ien, ctl_rd};
      default:  cpu_rdata = '0;
    endcase
  end

  // R2: the data latch only moves on a data write
  p_data_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && cpu_addr == OFS_DATA) |=> $stable(data_pin_out));
  // R4: setting the direction bit releases the data drivers
  p_bidir_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cpu_addr == OFS_CTRL && cpu_wdata[5]) |=> !data_pin_oe);
  // R9: 0100 on the line bits releases all four lines
  p_release_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cpu_addr == OFS_CTRL && cpu_wdata[3:0] == 4'b0100)
    |=> (ctl_pin_drive_low == '0));
  // R6: status writes touch no output
  p_stat_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cpu_addr == OFS_STAT) |=> ($stable(data_pin_out) &&
      $stable(data_pin_oe) && $stable(ctl_pin_drive_low) && $stable(irq_oe)));
endmodule

// File: tb/pport_regs_tb.sv
`timescale 1ns/1ps
module pport_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cpu_sel, cpu_wr;
  logic [1:0] cpu_addr;
  logic [7:0] cpu_wdata, cpu_rdata;
  logic [7:0] data_pin_out, data_pin_in, ext_data;
  logic       data_pin_oe;
  logic [3:0] ctl_pin_drive_low, ctl_pin_in, ext_pull;
  logic [4:0] stat_pin_in;
  logic       irq_pulse, irq_oe;

  int checks = 0;
  int errors = 0;
  int irq_cnt = 0;
  bit done = 0;

  logic [7:0] m_data;
  logic [5:0] m_ctrl;

  always #2.5 clk = ~clk;

  // pin models: bus driven by host unless released; open-collector wired-AND
  assign data_pin_in = data_pin_oe ? data_pin_out : ext_data;
  assign ctl_pin_in  = ~(ctl_pin_drive_low | ext_pull);

  always @(posedge clk) if (rst_n && irq_pulse) irq_cnt <= irq_cnt + 1;

  pport_regs u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .data_pin_out(data_pin_out), .data_pin_oe(data_pin_oe),
    .data_pin_in(data_pin_in), .ctl_pin_drive_low(ctl_pin_drive_low),
    .ctl_pin_in(ctl_pin_in), .stat_pin_in(stat_pin_in),
    .irq_pulse(irq_pulse), .irq_oe(irq_oe)
  );

  function automatic logic [3:0] f_drive(input logic [3:0] lines);
    return lines ~^ 4'b1011;
  endfunction

  function automatic logic [7:0] f_ctrl_rd(input logic [5:0] c, input logic [3:0] pull);
    logic [3:0] pin;
    pin = ~(f_drive(c[3:0]) | pull);
    return {2'b00, c[5:4], pin ^ 4'b1011};
  endfunction

  function automatic logic [7:0] f_stat_rd(input logic [4:0] s);
    return {~s[4], s[3:0], 3'b111};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_sel = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 1'b0; cpu_wr = 1'b0;
    if (a == 2'd0) m_data = d;
    if (a == 2'd2) m_ctrl = d[5:0];
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cpu_addr = a;
    #1 d = cpu_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [7:0] v;
    rd(2'd0, v); chk({tag, " R3 data read"}, v, m_ctrl[5] ? ext_data : m_data);
    rd(2'd1, v); chk({tag, " R5 status read"}, v, f_stat_rd(stat_pin_in));
    rd(2'd2, v); chk({tag, " R8 ctrl read"}, v, f_ctrl_rd(m_ctrl, ext_pull));
    chk({tag, " R7 drive"}, {4'h0, ctl_pin_drive_low}, {4'h0, f_drive(m_ctrl[3:0])});
    chk({tag, " R4 oe"}, {7'h0, data_pin_oe}, {7'h0, ~m_ctrl[5]});
    chk({tag, " R2 latch"}, data_pin_out, m_data);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int base;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cpu_sel = 0; cpu_wr = 0; cpu_addr = 0; cpu_wdata = 0;
    ext_data = 8'h00; ext_pull = 4'h0; stat_pin_in = 5'b01000;
    m_data = 8'h00; m_ctrl = 6'h04;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();

    // R1 reset state
    chk("R1 data latch", data_pin_out, 8'h00);
    chk("R1 oe", {7'h0, data_pin_oe}, 8'h01);
    chk("R1 drive", {4'h0, ctl_pin_drive_low}, 8'h00);
    chk("R1 irq_oe", {7'h0, irq_oe}, 8'h00);
    rd(2'd2, v); chk("R1 ctrl read", v, 8'h04);

    // R2/R3 write and hold
    wr(2'd0, 8'hA5); settle();
    rd(2'd0, v); chk("R3 data pin read", v, 8'hA5);
    repeat (5) @(negedge clk);
    chk("R2 hold", data_pin_out, 8'hA5);

    // R4 input mode: external byte read, write stored not driven
    ext_data = 8'h3C;
    wr(2'd2, 8'h24); settle();
    chk("R4 oe low", {7'h0, data_pin_oe}, 8'h00);
    rd(2'd0, v); chk("R4 ext read", v, 8'h3C);
    wr(2'd0, 8'h5A); settle();
    rd(2'd0, v); chk("R4 still ext", v, 8'h3C);
    wr(2'd2, 8'h04); settle();
    rd(2'd0, v); chk("R4 stored byte driven", v, 8'h5A);

    // R6 status write ignored; R13 offset 3
    stat_pin_in = 5'b10101; settle();
    wr(2'd1, 8'hFF); wr(2'd3, 8'hFF); settle();
    check_all("R6");
    rd(2'd3, v); chk("R13 offset3 read", v, 8'h00);

    // R9 release, R8 external pull, R10 pad bits
    wr(2'd2, 8'hCB); settle();
    check_all("R7");
    wr(2'd2, 8'h04); ext_pull = 4'b0101; settle();
    chk("R9 released", {4'h0, ctl_pin_drive_low}, 8'h00);
    rd(2'd2, v); chk("R8 pulled visible", v, 8'h04 ^ 8'h01 ^ 8'h04);
    ext_pull = 4'h0;
    wr(2'd2, 8'hF4); settle();
    rd(2'd2, v); chk("R10 pad and mode bits", v, 8'h34);
    wr(2'd2, 8'h04); settle();

    // R11/R12 interrupt
    stat_pin_in = 5'b01000; wr(2'd2, 8'h14); settle();
    chk("R12 irq_oe enabled", {7'h0, irq_oe}, 8'h01);
    base = irq_cnt;
    stat_pin_in[3] = 1'b0; repeat (6) @(negedge clk);
    chk("R11 one pulse on fall", 8'(irq_cnt - base), 8'd1);
    stat_pin_in[3] = 1'b1; repeat (6) @(negedge clk);
    chk("R11 none on rise", 8'(irq_cnt - base), 8'd1);
    wr(2'd2, 8'h04); settle();
    chk("R12 irq_oe disabled", {7'h0, irq_oe}, 8'h00);
    stat_pin_in[3] = 1'b0; repeat (6) @(negedge clk);
    chk("R12 no pulse disabled", 8'(irq_cnt - base), 8'd1);

    // random mix
    for (int i = 0; i < 40; i++) begin
      ext_data = 8'($urandom);
      ext_pull = 4'($urandom);
      stat_pin_in = 5'($urandom);
      wr(2'($urandom_range(0, 3)), 8'($urandom));
      wr(2'd2, 8'($urandom) & 8'hEF);
      wr(2'd0, 8'($urandom));
      settle();
      check_all("rand");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule